// File: doc/BRIEF.md
# JTAG Command Byte Engine

This block turns a stream of host command bytes into activity on a JTAG port. A command byte either places the port pins in a given state right away, or it announces that a number of following bytes are shift data. Each shift data byte is then clocked out, least significant bit first, through eight full TCK pulses. A read flag in a command asks the engine to send captured TDO data back through a byte output stream.

Bytes arrive over a valid/ready input and results leave over a valid/ready output. The pin outputs are registered. The length of each TCK phase is set by a parameter, so the engine can be slowed down to suit slow targets. Besides TCK, TMS and TDI, the engine drives a chip-enable, a chip-select and an output-enable, and it keeps all three at the values given by the last pin-setting command.

Top module: `jtag_cmd_engine`

## Requirements
- R1: After reset, all six pin outputs are low, rsp_valid is low, cmd_ready is high, and the first byte accepted is treated as a command.
- R2: A command with bit 7 clear sets the pins from the byte, taking effect in the cycle after acceptance: bit 0 sets tck, bit 1 tms, bit 2 ce_n, bit 3 cs_n, bit 4 tdi and bit 5 out_en.
- R3: A command with bit 7 clear and bit 6 set returns one byte whose bit 0 is tdo as sampled in the accepting cycle, whose bit 1 is 1, and whose other bits are 0. With bit 6 clear, no byte is returned.
- R4: A command with bit 7 set leaves every pin unchanged and returns nothing. Its bits 5..0 give the number of following bytes to treat as shift data.
- R5: A count of zero arms no data bytes, so the next byte is treated as a command.
- R6: Each data byte is shifted in 8 steps, LSB first. In each step tdi carries the current register LSB for the whole step, tdo is shifted into the register MSB, and tck makes one low-then-high pulse. When the byte is accepted, tck is forced low and tdi takes bit 0 of the byte.
- R7: Each tck low phase and each high phase lasts TCK_HALF clock cycles. tdo is sampled on the clock edge at which tck rises, so the sampled value is the one before the rise. tck ends low after the eighth step.
- R8: If bit 6 was set on the command that armed the count, the 8-bit register contents are returned after each byte's eighth step. Otherwise nothing is returned for data bytes.
- R9: Once the counted data bytes have all been shifted, the next byte is treated as a command.
- R10: cmd_ready is low while a byte is being shifted and while a result byte is waiting to be taken. A waiting result keeps rsp_valid high and rsp_data unchanged until rsp_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_data | input | 8 | Command or shift data byte |
| cmd_valid | input | 1 | cmd_data is offered |
| cmd_ready | output | 1 | Engine accepts cmd_data this cycle |
| rsp_data | output | 8 | Returned byte |
| rsp_valid | output | 1 | rsp_data is offered |
| rsp_ready | input | 1 | Sink takes rsp_data this cycle |
| tdo | input | 1 | Test data from the target |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to the target |
| ce_n | output | 1 | Auxiliary chip-enable level |
| cs_n | output | 1 | Auxiliary chip-select level |
| out_en | output | 1 | Output-enable level |

## Verification
The assertions assume that the sink obeys the output handshake, so a waiting result leaves only when rsp_ready is high. They also assume that the input side holds cmd_data steady while cmd_valid is high and cmd_ready is low. The stimulus keeps to both assumptions. It changes inputs only on the falling clock edge, and it holds each offered byte until a rising edge at which cmd_ready is high. tdo and rsp_ready come from a free-running pseudo-random source, with stretches where rsp_ready stays low to build back-pressure. tdo may change in any cycle, because the engine samples it only at defined edges.

// File: rtl/jeng_pkg.sv
package jeng_pkg;

    typedef enum logic {
        ENG_IDLE  = 1'b0,
        ENG_SHIFT = 1'b1
    } eng_mode_t;

    typedef struct packed {
        logic tck;
        logic tms;
        logic ce_n;
        logic cs_n;
        logic tdi;
        logic oe;
    } pin_set_t;

    localparam int unsigned CNT_W = 6;

endpackage

// File: rtl/jeng_cmd_decode.sv
module jeng_cmd_decode
    import jeng_pkg::*;
(
    input  logic [7:0]       byte_i,
    input  logic             tdo_i,
    output pin_set_t         pins_o,
    output logic             arm_o,
    output logic             rd_o,
    output logic [CNT_W-1:0] count_o,
    output logic [7:0]       status_o
);
    always_comb begin
        pins_o.tck  = byte_i[0];
        pins_o.tms  = byte_i[1];
        pins_o.ce_n = byte_i[2];
        pins_o.cs_n = byte_i[3];
        pins_o.tdi  = byte_i[4];
        pins_o.oe   = byte_i[5];
        rd_o        = byte_i[6];
        arm_o       = byte_i[7];
        count_o     = byte_i[CNT_W-1:0];
        // second status line is not wired and reads as one
        status_o    = {6'b0, 1'b1, tdo_i};
    end
endmodule

// File: rtl/jeng_phase_timer.sv
module jeng_phase_timer #(
    parameter int unsigned TCK_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expire_o
);
    localparam int unsigned PH_W = (TCK_HALF > 1) ? $clog2(TCK_HALF) : 1;
    localparam logic [PH_W-1:0] LAST = PH_W'(TCK_HALF - 1);

    logic [PH_W-1:0] cnt_d, cnt_q;

    assign expire_o = run_i && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i || expire_o) cnt_d = '0;
        else                    cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    initial begin
        if (TCK_HALF < 1) $error("TCK_HALF must be at least 1");
    end
endmodule

// File: rtl/jtag_cmd_engine.sv
module jtag_cmd_engine
    import jeng_pkg::*;
#(
    parameter int unsigned TCK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] cmd_data,
    input  logic       cmd_valid,
    output logic       cmd_ready,
    output logic [7:0] rsp_data,
    output logic       rsp_valid,
    input  logic       rsp_ready,
    input  logic       tdo,
    output logic       tck,
    output logic       tms,
    output logic       tdi,
    output logic       ce_n,
    output logic       cs_n,
    output logic       out_en
);
    localparam int unsigned STEP_W = 3;
    localparam logic [STEP_W-1:0] LAST_STEP = '1;

    typedef struct packed {
        eng_mode_t         mode;
        pin_set_t          pins;
        logic [7:0]        sreg;
        logic [CNT_W-1:0]  remain;
        logic              rd;
        logic [STEP_W-1:0] step;
        logic              rv;
        logic [7:0]        rdat;
    } eng_st_t;

    eng_st_t st_d, st_q;

    pin_set_t         dec_pins;
    logic             dec_arm;
    logic             dec_rd;
    logic [CNT_W-1:0] dec_count;
    logic [7:0]       dec_status;
    logic             ph_end;
    logic             accept;

    jeng_cmd_decode u_dec (
        .byte_i   (cmd_data),
        .tdo_i    (tdo),
        .pins_o   (dec_pins),
        .arm_o    (dec_arm),
        .rd_o     (dec_rd),
        .count_o  (dec_count),
        .status_o (dec_status)
    );

    jeng_phase_timer #(.TCK_HALF(TCK_HALF)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (st_q.mode == ENG_SHIFT),
        .expire_o (ph_end)
    );

    assign cmd_ready = (st_q.mode == ENG_IDLE) && !st_q.rv;
    assign accept    = cmd_valid && cmd_ready;

    always_comb begin
        st_d = st_q;
        if (st_q.rv && rsp_ready) st_d.rv = 1'b0;

        if (st_q.mode == ENG_SHIFT) begin
            if (ph_end) begin
                if (!st_q.pins.tck) begin
                    // end of low phase: capture, then raise the clock
                    st_d.sreg     = {tdo, st_q.sreg[7:1]};
                    st_d.pins.tck = 1'b1;
                end else begin
                    st_d.pins.tck = 1'b0;
                    if (st_q.step == LAST_STEP) begin
                        st_d.mode = ENG_IDLE;
                        st_d.step = '0;
                        if (st_q.rd) begin
                            st_d.rv   = 1'b1;
                            st_d.rdat = st_q.sreg;
                        end
                    end else begin
                        st_d.step     = st_q.step + 1'b1;
                        st_d.pins.tdi = st_q.sreg[0];
                    end
                end
            end
        end else if (accept) begin
            if (st_q.remain != '0) begin
                st_d.sreg     = cmd_data;
                st_d.remain   = st_q.remain - 1'b1;
                st_d.mode     = ENG_SHIFT;
                st_d.step     = '0;
                st_d.pins.tck = 1'b0;
                st_d.pins.tdi = cmd_data[0];
            end else begin
                st_d.rd = dec_rd;
                if (dec_arm) begin
                    st_d.remain = dec_count;
                end else begin
                    st_d.pins = dec_pins;
                    if (dec_rd) begin
                        st_d.rv   = 1'b1;
                        st_d.rdat = dec_status;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_data  = st_q.rdat;
    assign rsp_valid = st_q.rv;
    assign tck       = st_q.pins.tck;
    assign tms       = st_q.pins.tms;
    assign tdi       = st_q.pins.tdi;
    assign ce_n      = st_q.pins.ce_n;
    assign cs_n      = st_q.pins.cs_n;
    assign out_en    = st_q.pins.oe;

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == ENG_SHIFT) |-> !cmd_ready); // R10

    AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R10

    AST_TDI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == ENG_SHIFT && tck) |-> $stable(tdi)); // R6

    AST_ARM_KEEPS_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && st_q.remain == '0 && cmd_data[7])
            |=> ($stable(tck) && $stable(tms) && $stable(tdi) && $stable(ce_n)
                 && $stable(cs_n) && $stable(out_en))); // R4

    AST_ARM_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && st_q.remain == '0 && cmd_data[7]) |=> !rsp_valid); // R4
endmodule

// File: tb/jtag_cmd_engine_bench.sv
module jtag_cmd_engine_bench;
    localparam int TB_HALF = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cmd_data = '0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [7:0] rsp_data;
    logic       rsp_valid;
    logic       rsp_ready = 1'b1;
    logic       tdo = 1'b0;
    logic       tck, tms, tdi, ce_n, cs_n, out_en;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit rr_hold_low = 0;

    always #5 clk = ~clk;

    jtag_cmd_engine #(.TCK_HALF(TB_HALF)) u_jtag_cmd_engine (
        .clk(clk), .rst_n(rst_n), .cmd_data(cmd_data), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .rsp_data(rsp_data), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .tdo(tdo), .tck(tck), .tms(tms), .tdi(tdi),
        .ce_n(ce_n), .cs_n(cs_n), .out_en(out_en)
    );

    // reference model state
    typedef struct { bit tck; bit tdi; bit samp; bit last; } ev_t;
    ev_t  sched[$];
    bit   m_tck, m_tms, m_tdi, m_ce, m_cs, m_oe;
    bit   m_rv;
    logic [7:0] m_rdat;
    logic [7:0] m_cap;
    int   m_pend;
    bit   m_rd;
    bit   m_rdy;

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            sched.delete();
            {m_tck, m_tms, m_tdi, m_ce, m_cs, m_oe} = '0;
            m_rv = 0; m_rdat = '0; m_cap = '0; m_pend = 0; m_rd = 0;
        end else begin
            m_rdy = (sched.size() == 0) && !m_rv;
            if (m_rv && rsp_ready) m_rv = 0;
            if (sched.size() > 0) begin
                ev_t e;
                e = sched.pop_front();
                m_tck = e.tck;
                m_tdi = e.tdi;
                if (e.samp) m_cap = {tdo, m_cap[7:1]};
                if (e.last && m_rd) begin m_rv = 1; m_rdat = m_cap; end
            end else if (cmd_valid && m_rdy) begin
                if (m_pend > 0) begin
                    logic [8:0] ext;
                    ext = {cmd_data[7], cmd_data};
                    m_pend--;
                    m_cap = cmd_data;
                    m_tck = 0;
                    m_tdi = cmd_data[0];
                    for (int k = 0; k < 8; k++) begin
                        for (int j = 0; j < TB_HALF - 1; j++) sched.push_back('{0, ext[k], 0, 0});
                        sched.push_back('{1, ext[k], 1, 0});
                        for (int j = 0; j < TB_HALF - 1; j++) sched.push_back('{1, ext[k], 0, 0});
                        sched.push_back('{0, (k == 7) ? ext[7] : ext[k+1], 0, k == 7});
                    end
                end else begin
                    m_rd = cmd_data[6];
                    if (cmd_data[7]) m_pend = int'(cmd_data[5:0]);
                    else begin
                        {m_oe, m_tdi, m_cs, m_ce, m_tms, m_tck} = cmd_data[5:0];
                        if (cmd_data[6]) begin m_rv = 1; m_rdat = {6'b0, 1'b1, tdo}; end
                    end
                end
            end
        end
    end

    // compare every cycle away from the active edge, then move tdo / rsp_ready
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk("R7", "tck", {7'b0, tck}, {7'b0, m_tck});
            chk("R6", "tdi", {7'b0, tdi}, {7'b0, m_tdi});
            chk("R2", "tms/ce_n/cs_n/out_en", {4'b0, tms, ce_n, cs_n, out_en}, {4'b0, m_tms, m_ce, m_cs, m_oe});
            chk("R10", "cmd_ready", {7'b0, cmd_ready}, {7'b0, (sched.size() == 0) && !m_rv});
            chk("R8", "rsp_valid", {7'b0, rsp_valid}, {7'b0, m_rv});
            if (m_rv) chk("R3", "rsp_data", rsp_data, m_rdat);
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tdo = lfsr[0];
        rsp_ready = rr_hold_low ? 1'b0 : (lfsr[3] | lfsr[7]);
    end

    task automatic send(input logic [7:0] b);
        logic r;
        cmd_data = b;
        cmd_valid = 1'b1;
        forever begin
            r = cmd_ready;
            @(negedge clk);
            if (r) break;
        end
        cmd_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "pins after reset", {2'b0, out_en, tdi, cs_n, ce_n, tms, tck}, 8'h00);
        chk("R1", "ready after reset", {6'b0, cmd_ready, rsp_valid}, 8'b10);

        // R2: pin-setting patterns
        send(8'h3F); idle(2);
        chk("R2", "all pins high", {2'b0, out_en, tdi, cs_n, ce_n, tms, tck}, 8'h3F);
        send(8'h15); send(8'h2A); send(8'h00); idle(2);

        // R3: bit-bang reads
        for (int i = 0; i < 6; i++) begin send(8'h40 | 8'(i * 7 & 8'h3F)); idle(1); end

        // R4 and R5: arm with zero count, next byte is a pin command
        send(8'h80); idle(2);
        send(8'h02); idle(2);
        chk("R5", "tms after zero-count arm", {7'b0, tms}, 8'h01);
        send(8'hC0); send(8'h01); idle(2);
        chk("R5", "tck after zero-count read arm", {7'b0, tck}, 8'h01);

        // R6, R7, R9: write-only shifts, then a command
        send(8'h83); send(8'hA5); send(8'h3C); send(8'hFF);
        send(8'h0B); idle(2);
        chk("R9", "command after burst", {4'b0, cs_n, ce_n, tms, tck}, 8'h0B);

        // R8: shifts with read-back
        send(8'hC2); send(8'h96); send(8'h01);
        send(8'h40); idle(20);

        // R10: back-pressure on results
        rr_hold_low = 1;
        send(8'h41); idle(8);
        chk("R10", "ready held low while result waits", {7'b0, cmd_ready}, 8'h00);
        rr_hold_low = 0;
        send(8'hC3); send(8'h5A); send(8'h00); send(8'hE7);
        rr_hold_low = 1; idle(60); rr_hold_low = 0;

        // long burst at the largest count
        send(8'hFF);
        for (int i = 0; i < 63; i++) send(8'(i * 37 + 11));
        send(8'h55); idle(40);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule